// File: doc/BRIEF.md
# Multistage CIC Interpolation Filter

This block raises the sample rate of a signed stream by an integer factor using a cascade of comb and integrator sections built only from adders, subtractors and registers. The combs run at the low input rate with a single-sample delay each. A zero-insertion stage then pads every accepted sample with RATE−1 zeros. The integrators run at the high output rate. The overall response is that of STAGES cascaded length-RATE moving sums applied to the zero-padded stream. With one section, the block behaves as a sample-and-hold repeater.

The high-rate side advances once per `hi_en` pulse. The block pulls one input sample on every RATE-th enable and flags that enable on `smp_req`. The upstream source must hold `smp_data` valid during that cycle. The datapath is sized so that the full gain of RATE^(STAGES−1) fits without wrap. A parameter can keep only the upper bits of the result.

Top module: `cic_interp`

## Requirements
- R1: A synchronous reset clears every comb delay, every integrator and the phase counter. After reset, `out_vld` is 0 and `out_data` is 0, and the first enable that follows takes an input sample.
- R2: `smp_req` is high only in a cycle with `hi_en` high, and only on enables numbered 0, RATE, 2·RATE, … counted from reset. `smp_data` is read only in those cycles, and its value at any other time has no effect on the output.
- R3: `out_vld` rises in the cycle after each `hi_en` cycle, and `out_data` then holds the new result. After a cycle with `hi_en` low, `out_vld` is 0 and `out_data` keeps its previous value.
- R4: On every enable k, the full-precision output equals the zero-padded input stream passed through STAGES moving sums of length RATE. The stream holds the sample on enables where k mod RATE = 0 and zero elsewhere. The output has zero latency in enables, so the result for enable k appears after that enable's clock edge.
- R5: A constant input x settles to x·RATE^(STAGES−1).
- R6: With STAGES = 1, every output equals the most recently accepted input sample, so each sample is repeated RATE times.
- R7: The internal width is IN_W + ceil(log2(RATE^(STAGES−1))). No input sequence, including a sustained most-negative value, wraps the output.
- R8: When OUT_W is narrower than the full width, `out_data` is the full result shifted right arithmetically by (full width − OUT_W) bits, which is a floor division by that power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_en | input | 1 | High-rate enable; one output step per pulse |
| smp_req | output | 1 | High in the enable cycle in which `smp_data` is taken |
| smp_data | input | IN_W | Signed low-rate input sample |
| out_vld | output | 1 | Registered strobe: `out_data` updated this cycle |
| out_data | output | OUT_W | Signed interpolated output |

## Verification
The properties assume that `hi_en` is the only event that moves the state, and that a sample is taken on exactly one enable out of every RATE. Between enables, the integrators and comb delays must stay still, and on enables that carry no sample, the first integrator must see a zero. The stimulus uses the enable as the only pacing signal, with both continuous and randomly gapped patterns. It changes `smp_data` freely on cycles that take no sample, and places each pattern value on an enable that does take one. It forces a reset between phases, so each phase starts from a known, cleared state.

// File: rtl/cic_interp_pkg.sv
package cic_interp_pkg;

    // Bits needed to hold the interpolator gain RATE^(STAGES-1).
    function automatic int gain_bits(input int rate, input int stages);
        longint g;
        int     r;
        g = 1;
        r = 0;
        for (int i = 1; i < stages; i++) g = g * rate;
        while ((longint'(1) << r) < g) r++;
        return r;
    endfunction

endpackage

// File: rtl/cic_phase_gen.sv
module cic_phase_gen #(
    parameter int RATE = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic take
);
    localparam int PH_W = (RATE > 1) ? $clog2(RATE) : 1;

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (st_q.phase == PH_W'(RATE - 1)) st_d.phase = '0;
            else                               st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign take = en && (st_q.phase == '0);

endmodule

// File: rtl/cic_comb_bank.sv
module cic_comb_bank #(
    parameter int W      = 16,
    parameter int STAGES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic signed [W-1:0] x_in,
    output logic signed [W-1:0] c_out
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] dly;
    } comb_state_t;

    comb_state_t st_d, st_q;
    logic signed [W-1:0] tap [STAGES+1];

    // Differences at the low rate with a one-sample delay per section.
    assign tap[0] = x_in;
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_sec
            assign tap[i+1] = tap[i] - $signed(st_q.dly[i]);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (take) begin
            for (int i = 0; i < STAGES; i++) st_d.dly[i] = tap[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign c_out = tap[STAGES];

    AST_COMB_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(st_q.dly)); // R2

endmodule

// File: rtl/cic_integ_bank.sv
module cic_integ_bank #(
    parameter int W      = 16,
    parameter int STAGES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                take,
    input  logic signed [W-1:0] u_in,
    output logic signed [W-1:0] y_out
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] acc;
    } integ_state_t;

    integ_state_t st_d, st_q;
    logic [W-1:0] carry;

    // Zero insertion feeds the first section; the chain settles in one cycle.
    always_comb begin
        st_d  = st_q;
        carry = take ? u_in : '0;
        if (en) begin
            for (int j = 0; j < STAGES; j++) begin
                st_d.acc[j] = st_q.acc[j] + carry;
                carry       = st_d.acc[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign y_out = $signed(st_q.acc[STAGES-1]);

    AST_INTEG_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st_q.acc)); // R3
    AST_ZERO_GAP_FLAT: assert property (@(posedge clk) disable iff (rst)
        (en && !take) |=> (st_q.acc[0] == $past(st_q.acc[0]))); // R4

endmodule

// File: rtl/cic_interp.sv
module cic_interp
    import cic_interp_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int RATE   = 10,
    parameter int STAGES = 4,
    parameter int OUT_W  = IN_W + gain_bits(RATE, STAGES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hi_en,
    output logic                    smp_req,
    input  logic signed [IN_W-1:0]  smp_data,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int FULL_W = IN_W + gain_bits(RATE, STAGES);
    localparam int DROP   = FULL_W - OUT_W;

    typedef struct packed {
        logic vld;
    } top_state_t;

    top_state_t st_d, st_q;
    logic take;
    logic signed [FULL_W-1:0] x_ext, comb_y, integ_y;

    assign x_ext = FULL_W'(smp_data);

    cic_phase_gen #(.RATE(RATE)) phase_i (
        .clk (clk), .rst (rst), .en (hi_en), .take (take)
    );

    cic_comb_bank #(.W(FULL_W), .STAGES(STAGES)) comb_i (
        .clk (clk), .rst (rst), .take (take), .x_in (x_ext), .c_out (comb_y)
    );

    cic_integ_bank #(.W(FULL_W), .STAGES(STAGES)) integ_i (
        .clk (clk), .rst (rst), .en (hi_en), .take (take),
        .u_in (comb_y), .y_out (integ_y)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = hi_en;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign smp_req  = take;
    assign out_vld  = st_q.vld;
    assign out_data = integ_y[FULL_W-1 -: OUT_W];

    generate
        if (DROP > 0) begin : g_trunc
            logic unused_low;
            assign unused_low = ^integ_y[DROP-1:0];
        end
    endgenerate

    // Independent spacing monitor for accepted samples.
    logic [31:0] gap_q;
    logic        seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (hi_en) begin
            gap_q  <= smp_req ? 32'd0 : gap_q + 32'd1;
            seen_q <= seen_q | smp_req;
        end
    end

    AST_TAKE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (smp_req && seen_q) |-> (gap_q == 32'(RATE - 1))); // R2
    AST_TAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !hi_en |-> !smp_req); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hi_en |=> $stable(out_data)); // R3

endmodule

// File: tb/cic_interp_tb_top.sv
module cic_interp_tb_top;
    localparam int IN_W = 6;
    localparam int NR   = 5;
    localparam int NS   = 3;
    localparam int FW   = IN_W + 5;   // ceil(log2(5^2)) = 5
    localparam int TW   = 7;
    localparam int SH   = FW - TW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hi_en = 1'b0;
    logic signed [IN_W-1:0] din = '0;
    logic smp_req, smp_req_t, smp_req_z;
    logic vld, vld_t, vld_z;
    logic signed [FW-1:0]   y_full;
    logic signed [TW-1:0]   y_tr;
    logic signed [IN_W-1:0] y_zoh;

    always #4 clk = ~clk;

    cic_interp #(.IN_W(IN_W), .RATE(NR), .STAGES(NS)) dut_i (
        .clk(clk), .rst(rst), .hi_en(hi_en), .smp_req(smp_req),
        .smp_data(din), .out_vld(vld), .out_data(y_full));
    cic_interp #(.IN_W(IN_W), .RATE(NR), .STAGES(NS), .OUT_W(TW)) dut_trunc_i (
        .clk(clk), .rst(rst), .hi_en(hi_en), .smp_req(smp_req_t),
        .smp_data(din), .out_vld(vld_t), .out_data(y_tr));
    cic_interp #(.IN_W(IN_W), .RATE(NR), .STAGES(1)) dut_zoh_i (
        .clk(clk), .rst(rst), .hi_en(hi_en), .smp_req(smp_req_z),
        .smp_data(din), .out_vld(vld_z), .out_data(y_zoh));

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    longint hist [NS][NR];
    longint ecount, exp_full, exp_zoh, zoh_hold, last_out;
    int take_idx;
    bit prev_en;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model_step(input bit tk, input longint x);
        longint v, s;
        v = tk ? x : 0;
        for (int st = 0; st < NS; st++) begin
            for (int t = NR - 1; t > 0; t--) hist[st][t] = hist[st][t-1];
            hist[st][0] = v;
            s = 0;
            for (int t = 0; t < NR; t++) s += hist[st][t];
            v = s;
        end
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; hi_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int st = 0; st < NS; st++)
            for (int t = 0; t < NR; t++) hist[st][t] = 0;
        ecount = 0; take_idx = 0; zoh_hold = 0; prev_en = 0; last_out = 0;
        chk("R1 out_vld after reset", longint'(vld), 0);
        chk("R1 out_data after reset", longint'(y_full), 0);
        chk("R1 zoh out after reset", longint'(y_zoh), 0);
    endtask

    task automatic check_prev();
        if (prev_en) begin
            chk("R3 out_vld after enable", longint'(vld), 1);
            chk("R4 full output", longint'(y_full), exp_full);
            chk("R8 truncated output", longint'(y_tr), exp_full >>> SH);
            chk("R6 hold output", longint'(y_zoh), exp_zoh);
        end else begin
            chk("R3 out_vld idle", longint'(vld), 0);
            chk("R3 out_data held", longint'(y_full), last_out);
        end
        last_out = longint'(y_full);
    endtask

    // mode 0 impulse, 1 step +31, 2 step -32, 3 random
    task automatic run(input int cycles, input int mode, input int en_pct);
        bit en, tk;
        longint xv;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            check_prev();
            en = (($urandom % 100) < en_pct);
            tk = en && ((ecount % NR) == 0);
            din = IN_W'($urandom);
            if (tk) begin
                case (mode)
                    0: din = (take_idx == 0) ? 6'sd1 : 6'sd0;
                    1: din = 6'sd31;
                    2: din = -6'sd32;
                    default: ;
                endcase
                take_idx++;
            end
            hi_en = en;
            xv = longint'(din);
            #1;
            chk("R2 smp_req", longint'(smp_req), longint'(tk));
            if (en) begin
                exp_full = model_step(tk, xv);
                if (tk) zoh_hold = xv;
                exp_zoh = zoh_hold;
                ecount++;
            end
            prev_en = en;
        end
        @(negedge clk);
        check_prev();
        hi_en = 1'b0;
        prev_en = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        run(120, 0, 100);                       // R4 impulse response, continuous enable
        do_reset();
        run(200, 1, 100);                       // R5 positive step
        chk("R5 settled gain", longint'(y_full), 31 * NR * NR);
        do_reset();
        run(300, 2, 70);                        // R7 negative full scale, gapped enable
        chk("R7 most negative settles without wrap", longint'(y_full), -32 * NR * NR);
        chk("R8 most negative truncated", longint'(y_tr), (-32 * NR * NR) >>> SH);
        do_reset();
        run(3000, 3, 60);                       // R4 R6 R8 random data and gaps
        do_reset();
        run(1500, 3, 100);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule